// File: doc/BRIEF.md
# Instruction Prefetch Queue with Activity Status

This block sits between an instruction fetcher on the bus side and an instruction consumer on the execution side. The fetcher writes instruction bytes into a small circular store whenever a slot is free. The consumer removes bytes in arrival order and tags each removal as either the opening byte of an opcode or a later byte of the same instruction. The two sides make progress on their own, so fetching overlaps execution.

When the program flow changes, for example after a taken branch, the consumer raises a flush. The flush throws away every stored byte and resets the pointers. A two-bit activity code, registered once per clock, tells outside observers what the queue did on the last edge. The four possible events are: nothing, an opcode-start byte taken, a follow-on byte taken, or a flush.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `level` is 0, `take_ready` is 0, `fill_ready` is 1 and `qstat` is 2'b00.
- R2: A byte is stored when `fill_valid` is high and `fill_ready` is high. `fill_ready` is low exactly when `level` equals DEPTH (default 6). A write offered while full is dropped and never appears at `take_byte`.
- R3: `take_byte` always presents the oldest stored byte, and bytes leave in the order they were written.
- R4: When a write and a removal both happen on one edge, `level` is unchanged and the byte removed is the one that was oldest before the edge.
- R5: A flush has priority over any write or removal on the same edge. After that edge `level` is 0, a byte offered on that edge is discarded and no byte is removed.
- R6: `qstat` is registered. It shows the event of the most recent edge, with `qstat[1]` as the first status bit and `qstat[0]` as the second: 2'b00 no event, 2'b01 opcode-start byte removed (`take_first`=1), 2'b11 follow-on byte removed (`take_first`=0), 2'b10 queue flushed.
- R7: A removal request while empty is held off: `take_ready` is 0, nothing is removed, `level` is not lowered and `qstat` reports 2'b00.
- R8: Read and write positions wrap after slot DEPTH-1, so order is kept across any number of passes round the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Fetch side offers a byte |
| fill_byte | input | 8 | Byte offered by fetch side |
| fill_ready | output | 1 | A slot is free |
| take_req | input | 1 | Execute side asks to remove a byte |
| take_first | input | 1 | Removal is the first byte of an opcode |
| take_byte | output | 8 | Oldest stored byte |
| take_ready | output | 1 | At least one byte is stored |
| flush | input | 1 | Discard all contents |
| level | output | 3 | Number of stored bytes |
| qstat | output | 2 | Registered activity code for the last edge |

## Verification
A wrong pointer or a wrong occupancy count shows on the next edge in one of two ways. Either `level` drifts from the number of writes minus removals, or `take_byte` presents a byte out of order. The bench tracks both at every removal. A write lost while full, or a write that slips past a flush, would show up later as an extra or stale byte when the queue is drained. The drain tests therefore check the last byte and the final empty state. A wrong activity encoding is visible one cycle after the event, because `qstat` is registered.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;

  typedef enum logic [1:0] {
    QST_IDLE  = 2'b00,
    QST_FIRST = 2'b01,
    QST_FLUSH = 2'b10,
    QST_NEXT  = 2'b11
  } qstat_e;

  // Activity code for one edge; flush outranks a removal.
  function automatic qstat_e encode_activity(input logic fl, input logic popped,
                                             input logic first);
    if (fl)          return QST_FLUSH;
    else if (popped) return first ? QST_FIRST : QST_NEXT;
    else             return QST_IDLE;
  endfunction

endpackage

// File: rtl/pfq_store.sv
`timescale 1ns/1ps
module pfq_store #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PW'(i))) slots[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr == PW'(i)) rd_data = slots[i];
    end
  end

endmodule

// File: rtl/pfq_ptrs.sv
`timescale 1ns/1ps
module pfq_ptrs #(
  parameter int DEPTH = 6,
  parameter int PW    = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] level
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [CW-1:0] next_level(input logic [CW-1:0] l,
                                               input logic in, input logic out);
    case ({in, out})
      2'b10:   return l + CW'(1);
      2'b01:   return l - CW'(1);
      default: return l;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= next_level(level, push, pop);
    end
  end

endmodule

// File: rtl/pfq_status.sv
`timescale 1ns/1ps
module pfq_status
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flushed,
  input  logic       popped,
  input  logic       first,
  output logic [1:0] qstat
);

  qstat_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= QST_IDLE;
    else        code_q <= encode_activity(flushed, popped, first);
  end

  assign qstat = code_q;

endmodule

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int DW    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fill_valid,
  input  logic [DW-1:0] fill_byte,
  output logic        fill_ready,
  input  logic        take_req,
  input  logic        take_first,
  output logic [DW-1:0] take_byte,
  output logic        take_ready,
  input  logic        flush,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic [1:0]  qstat
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_fire, pop_fire;

  assign fill_ready = (level != CW'(DEPTH));
  assign take_ready = (level != '0);
  assign push_fire  = fill_valid & fill_ready & ~flush;
  assign pop_fire   = take_req & take_ready & ~flush;

  pfq_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
    .clk     (clk),
    .wr_en   (push_fire),
    .wr_ptr  (wr_ptr),
    .wr_data (fill_byte),
    .rd_ptr  (rd_ptr),
    .rd_data (take_byte)
  );

  pfq_ptrs #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_fire),
    .pop    (pop_fire),
    .clear  (flush),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .level  (level)
  );

  pfq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .flushed (flush),
    .popped  (pop_fire),
    .first   (take_first),
    .qstat   (qstat)
  );

endmodule

// File: rtl/pfq_checker.sv
`timescale 1ns/1ps
module pfq_checker #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          take_req,
  input logic          take_first,
  input logic          take_ready,
  input logic          push_fire,
  input logic          pop_fire,
  input logic [CW-1:0] level,
  input logic [1:0]    qstat
);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && !pop_fire && !flush) |=> level == CW'(DEPTH));

  p_pushpop_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire && !flush) |=> $stable(level));

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && qstat == 2'b10));

  p_first_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && take_first) |=> qstat == 2'b01);

  p_next_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !take_first) |=> qstat == 2'b11);

  p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !take_ready && !flush) |=> qstat == 2'b00);

endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH), .CW(CW)) u_pfq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .take_req   (take_req),
  .take_first (take_first),
  .take_ready (take_ready),
  .push_fire  (push_fire),
  .pop_fire   (pop_fire),
  .level      (level),
  .qstat      (qstat)
);

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;

  localparam int DEPTH = 6;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fill_valid = 1'b0;
  logic [7:0]    fill_byte = '0;
  logic          fill_ready;
  logic          take_req = 1'b0;
  logic          take_first = 1'b0;
  logic [7:0]    take_byte;
  logic          take_ready;
  logic          flush = 1'b0;
  logic [CW-1:0] level;
  logic [1:0]    qstat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prefetch_queue #(.DEPTH(DEPTH), .DW(8)) u_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_byte(fill_byte),
    .fill_ready(fill_ready), .take_req(take_req), .take_first(take_first),
    .take_byte(take_byte), .take_ready(take_ready), .flush(flush),
    .level(level), .qstat(qstat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    fill_valid = 1'b0; take_req = 1'b0; take_first = 1'b0; flush = 1'b0;
  endtask

  task automatic push1(input logic [7:0] b);
    fill_valid = 1'b1; fill_byte = b;
    cyc();
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", int'(level), 0);
    chk("R1 take_ready", int'(take_ready), 0);
    chk("R1 fill_ready", int'(fill_ready), 1);
    chk("R1 qstat", int'(qstat), 0);
  endtask

  // R2 fill to full, offered byte while full dropped; R3 drain in order; R6 codes
  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) push1(8'h10 + 8'(i));
    chk("R2 level full", int'(level), DEPTH);
    chk("R2 fill_ready low", int'(fill_ready), 0);
    chk("R6 idle after pushes", int'(qstat), 0);
    push1(8'hEE);
    chk("R2 level unchanged when full", int'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 head byte", int'(take_byte), 32'h10 + i);
      take_req = 1'b1; take_first = (i == 0);
      cyc();
      take_req = 1'b0;
      chk("R6 pop code", int'(qstat), (i == 0) ? 1 : 3);
    end
    chk("R2 no dropped byte left", int'(level), 0);
    chk("R2 take_ready after drain", int'(take_ready), 0);
  endtask

  task automatic t_empty_pop();
    take_req = 1'b1; take_first = 1'b1;
    cyc();
    chk("R7 take_ready", int'(take_ready), 0);
    chk("R7 qstat idle", int'(qstat), 0);
    chk("R7 level", int'(level), 0);
    idle_inputs();
  endtask

  task automatic t_pushpop();
    push1(8'hA1);
    push1(8'hA2);
    chk("R4 head before", int'(take_byte), 32'hA1);
    fill_valid = 1'b1; fill_byte = 8'hA3; take_req = 1'b1; take_first = 1'b1;
    cyc();
    idle_inputs();
    chk("R4 level unchanged", int'(level), 2);
    chk("R4 head advanced", int'(take_byte), 32'hA2);
    chk("R6 first code", int'(qstat), 1);
    take_req = 1'b1; take_first = 1'b0;
    cyc();
    idle_inputs();
    chk("R6 next code", int'(qstat), 3);
    chk("R4 newest kept", int'(take_byte), 32'hA3);
    take_req = 1'b1;
    cyc();
    idle_inputs();
    chk("R4 drained", int'(level), 0);
  endtask

  task automatic t_flush();
    push1(8'h31); push1(8'h32); push1(8'h33);
    flush = 1'b1; fill_valid = 1'b1; fill_byte = 8'h77; take_req = 1'b1; take_first = 1'b1;
    cyc();
    idle_inputs();
    chk("R5 level zero", int'(level), 0);
    chk("R5 take_ready low", int'(take_ready), 0);
    chk("R6 flush code", int'(qstat), 2);
    cyc();
    chk("R6 idle after flush", int'(qstat), 0);
    push1(8'h55);
    chk("R5 offered byte discarded", int'(take_byte), 32'h55);
    chk("R5 level one", int'(level), 1);
    take_req = 1'b1;
    cyc();
    idle_inputs();
  endtask

  // R8 wrap many times with steady push+pop
  task automatic t_wrap();
    logic [7:0] wr_v, rd_v;
    wr_v = 8'h80; rd_v = 8'h80;
    for (int i = 0; i < 3; i++) begin push1(wr_v); wr_v++; end
    for (int i = 0; i < 20; i++) begin
      chk("R8 wrap order", int'(take_byte), int'(rd_v));
      fill_valid = 1'b1; fill_byte = wr_v; take_req = 1'b1; take_first = 1'(i % 2);
      cyc();
      idle_inputs();
      wr_v++; rd_v++;
      chk("R8 wrap level", int'(level), 3);
    end
    for (int i = 0; i < 3; i++) begin
      chk("R8 tail order", int'(take_byte), int'(rd_v));
      take_req = 1'b1;
      cyc();
      idle_inputs();
      rd_v++;
    end
    chk("R8 empty at end", int'(level), 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_fill_drain();
    t_empty_pop();
    t_pushpop();
    t_flush();
    t_wrap();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

endmodule